// File: doc/BRIEF.md
# Shift-Then-Add Address Unit

This block is a single-stage integer unit that builds effective addresses. Each operation presents a 64-bit source split across two 32-bit words (an upper and a lower word), a 32-bit addend, a 5-bit immediate shift count and a half-select bit. The unit joins the two words, shifts the 64-bit value left through a barrel shifter, takes either the lower or the upper 32 bits of the shifted value, and adds the addend. The result is a 32-bit sum that wraps, together with the carry out of that addition.

A typical use is a row-major index such as `row*32 + col`. This needs an upper word of zero, a shift of 5 and lower-half mode. A full 64-bit address is built over two operations. A lower-half operation forms the low word. An upper-half operation on the same source forms the high word, and the caller can fold the first operation's carry into that addend.

Operations are accepted on any cycle where `in_valid` is high, so back-to-back issue is allowed. The result appears with `out_valid` exactly one clock later. A two-state machine tracks the output: `ST_EMPTY` means no result is presented and `ST_FULL` means a result is presented. The transitions are:
- `ACCEPT`: from `ST_EMPTY` to `ST_FULL` when `in_valid` is high.
- `REFILL`: `ST_FULL` stays in `ST_FULL` when `in_valid` is high.
- `DRAIN`: from `ST_FULL` to `ST_EMPTY` when `in_valid` is low.
- `IDLE`: `ST_EMPTY` stays in `ST_EMPTY` when `in_valid` is low.
- Reset forces `ST_EMPTY` from any state.

Top module: `sta_addr_unit`

## Requirements
- R1: A synchronous active-high `rst` sampled on a clock edge makes `out_valid`, `result` and `carry_out` all 0 after that edge.
- R2: `out_valid` is high in the cycle after an edge at which `in_valid` was high and `rst` low, and low in the cycle after an edge at which `in_valid` was low.
- R3: With `in_hi_mode` = 0, `result` equals bits 31:0 of ({`src_hi`,`src_lo`} << `shamt`) plus `addend`, modulo 2^32.
- R4: With `in_hi_mode` = 1, `result` equals bits 63:32 of ({`src_hi`,`src_lo`} << `shamt`) plus `addend`, modulo 2^32.
- R5: The shift treats `shamt` as an unsigned count from 0 to 31. A count of 0 leaves the 64-bit value unchanged. Bits shifted past bit 63 are lost, and zeros enter at bit 0.
- R6: `carry_out` is bit 32 of the 33-bit sum of the selected 32-bit half and `addend`.
- R7: `in_hi_mode` is encoded as 0 for the lower half and 1 for the upper half. The lower half is the default when the bit is held at 0.
- R8: Operations issued on consecutive cycles each produce their own result, one cycle after issue, with no lost or repeated results.
- R9: While no operation is accepted, `result` and `carry_out` keep the values of the last accepted operation.
- R10: When `rst` and `in_valid` are both high at the same edge, reset wins and `out_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_hi_mode | input | 1 | Half select: 0 = lower word, 1 = upper word |
| src_hi | input | 32 | Upper word of the 64-bit source |
| src_lo | input | 32 | Lower word of the 64-bit source |
| addend | input | 32 | Value added after the shift |
| shamt | input | 5 | Immediate left-shift count |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 32 | Selected half plus addend, wrapped to 32 bits |
| carry_out | output | 1 | Carry out of the 32-bit addition |

## Verification
Two things can land in the same cycle here. One is a fresh operation being captured while the previous result is still on the outputs. The other is a reset arriving on the same edge as an operation. The bench provokes the first with unbroken bursts of `in_valid` that mix modes and shift counts. Each cycle's output must then match the operation issued one edge earlier, never the one before it or after it. It provokes the second by raising `rst` together with `in_valid`. The bench judges both through its behavioural model: that model must then show an empty output and zeroed result, and a held result once the burst stops.

// File: rtl/sta_pkg.sv
package sta_pkg;
    parameter int unsigned DATA_W  = 32;
    parameter int unsigned SHAMT_W = 5;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_state_e;
endpackage

// File: rtl/sta_shifter.sv
module sta_shifter #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned CNT_W = 5
) (
    input  logic [WIDTH-1:0] din,
    input  logic [CNT_W-1:0] cnt,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [CNT_W+1];

    assign stage[0] = din;

    // One stage per bit of the count: stage i shifts by 2**i or passes through.
    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
        localparam int unsigned STEP = 1 << i;
        always_comb begin
            if (cnt[i]) begin
                stage[i+1] = {stage[i][WIDTH-1-STEP:0], {STEP{1'b0}}};
            end else begin
                stage[i+1] = stage[i];
            end
        end
    end

    assign dout = stage[CNT_W];
endmodule

// File: rtl/sta_half_adder.sv
module sta_half_adder #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] shifted,
    input  sta_pkg::half_e      half_sel,
    input  logic [DATA_W-1:0]   addend,
    output logic [DATA_W-1:0]   sum,
    output logic                carry
);
    logic [DATA_W-1:0] picked;
    logic [DATA_W:0]   wide;

    always_comb begin
        unique case (half_sel)
            sta_pkg::HALF_HI: picked = shifted[2*DATA_W-1:DATA_W];
            default:          picked = shifted[DATA_W-1:0];
        endcase
    end

    assign wide  = {1'b0, picked} + {1'b0, addend};
    assign sum   = wide[DATA_W-1:0];
    assign carry = wide[DATA_W];
endmodule

// File: rtl/sta_addr_unit.sv
module sta_addr_unit
    import sta_pkg::*;
#(
    parameter int unsigned DW = DATA_W,
    parameter int unsigned SW = SHAMT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_hi_mode,
    input  logic [DW-1:0] src_hi,
    input  logic [DW-1:0] src_lo,
    input  logic [DW-1:0] addend,
    input  logic [SW-1:0] shamt,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          carry_out
);
    localparam int unsigned CW = 2 * DW;

    out_state_e        state_q, state_d;
    logic [CW-1:0]     shifted;
    logic [DW-1:0]     sum_w;
    logic              carry_w;
    logic [DW-1:0]     result_q;
    logic              carry_q;
    half_e             half_sel;

    assign half_sel = in_hi_mode ? HALF_HI : HALF_LO;

    sta_shifter #(.WIDTH(CW), .CNT_W(SW)) u_shift (
        .din  ({src_hi, src_lo}),
        .cnt  (shamt),
        .dout (shifted)
    );

    sta_half_adder #(.DATA_W(DW)) u_add (
        .shifted  (shifted),
        .half_sel (half_sel),
        .addend   (addend),
        .sum      (sum_w),
        .carry    (carry_w)
    );

    // Next-state logic: ACCEPT / REFILL / DRAIN / IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;
            ST_FULL:  if (!in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            carry_q  <= 1'b0;
        end else if (in_valid) begin
            result_q <= sum_w;
            carry_q  <= carry_w;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        result    = result_q;
        carry_out = carry_q;
    end
endmodule

// File: rtl/sta_addr_unit_chk.sv
module sta_addr_unit_chk #(
    parameter int unsigned DW = 32,
    parameter int unsigned SW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_hi_mode,
    input logic [DW-1:0] src_hi,
    input logic [DW-1:0] src_lo,
    input logic [DW-1:0] addend,
    input logic [SW-1:0] shamt,
    input logic          out_valid,
    input logic [DW-1:0] result,
    input logic          carry_out
);
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && !carry_out)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2

    AST_LO_NOSHIFT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_hi_mode && shamt == '0)
        |=> result == $past(src_lo + addend)); // R3

    AST_HI_NOSHIFT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_hi_mode && shamt == '0)
        |=> result == $past(src_hi + addend)); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(carry_out))); // R9
endmodule

bind sta_addr_unit sta_addr_unit_chk #(.DW(DW), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi_mode(in_hi_mode),
    .src_hi(src_hi), .src_lo(src_lo), .addend(addend), .shamt(shamt),
    .out_valid(out_valid), .result(result), .carry_out(carry_out)
);

// File: tb/sta_addr_unit_test.sv
module sta_addr_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_hi_mode;
    logic [31:0] src_hi, src_lo, addend;
    logic [4:0]  shamt;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string cur_tag = "R3";

    // Reference model state
    bit          ref_v = 0;
    logic [31:0] ref_res = '0;
    bit          ref_c = 0;
    string       ref_tag = "R1";

    always #10 clk = ~clk;  // 50 MHz

    sta_addr_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi_mode(in_hi_mode),
        .src_hi(src_hi), .src_lo(src_lo), .addend(addend), .shamt(shamt),
        .out_valid(out_valid), .result(result), .carry_out(carry_out)
    );

    always @(posedge clk) begin
        longint unsigned whole, sh;
        longint unsigned half, s;
        if (rst) begin
            ref_v   <= 0;
            ref_res <= '0;
            ref_c   <= 0;
            ref_tag <= in_valid ? "R10" : "R1";
        end else if (in_valid) begin
            whole = {src_hi, src_lo};
            sh    = whole << shamt;
            half  = in_hi_mode ? (sh >> 32) : (sh & 64'hFFFF_FFFF);
            s     = half + longint'(addend);
            ref_v   <= 1;
            ref_res <= s[31:0];
            ref_c   <= s[32];
            ref_tag <= cur_tag;
        end else begin
            ref_v   <= 0;
            ref_tag <= "R9";
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done && rst !== 1'bx) begin
            check(out_valid == ref_v, (ref_tag == "R10" || ref_tag == "R1") ? ref_tag : "R2",
                  "out_valid", out_valid, ref_v);
            check(result == ref_res, ref_tag, "result", result, ref_res);
            check(carry_out == ref_c, (ref_tag == "R9" || ref_tag == "R1") ? ref_tag : "R6",
                  "carry_out", carry_out, ref_c);
        end
    end

    task automatic issue(input bit hi, input logic [31:0] h, input logic [31:0] l,
                         input logic [31:0] b, input logic [4:0] s, input string tag);
        in_valid = 1; in_hi_mode = hi; src_hi = h; src_lo = l; addend = b; shamt = s;
        cur_tag = tag;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        rst = 1; in_valid = 0; in_hi_mode = 0;
        src_hi = '0; src_lo = '0; addend = '0; shamt = '0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R3 / R7: row-major index y*32 + x with default lower mode
        issue(0, 32'h0, 32'd7, 32'd5, 5'd5, "R7");
        idle(2);  // R9 hold
        // R5: shift 0, 1, 31 and a mid value in both halves
        issue(0, 32'hDEAD_BEEF, 32'h1234_5678, 32'h0, 5'd0, "R5");
        issue(1, 32'hDEAD_BEEF, 32'h1234_5678, 32'h0, 5'd0, "R5");
        issue(0, 32'h8000_0001, 32'h8000_0001, 32'h1, 5'd1, "R5");
        issue(1, 32'h8000_0001, 32'h8000_0001, 32'h1, 5'd1, "R5");
        issue(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 5'd31, "R5");
        issue(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 5'd31, "R5");
        issue(1, 32'h0000_00FF, 32'hF000_0000, 32'h10, 5'd12, "R4");
        // R6: carry out of the add, lower then upper for a 64-bit address
        issue(0, 32'h0, 32'hFFFF_FFFF, 32'h1, 5'd0, "R6");
        issue(1, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 5'd0, "R6");
        idle(1);
        // R10: reset together with an operation
        rst = 1;
        issue(1, 32'h1, 32'h2, 32'h3, 5'd4, "R10");
        rst = 0;
        idle(1);
        // R8: random back-to-back bursts in both modes (R3/R4)
        for (int k = 0; k < 300; k++) begin
            logic [4:0] sv;
            bit hm;
            hm = 1'($urandom);
            case (k % 4)
                0: sv = 5'd0;
                1: sv = 5'd1;
                2: sv = 5'd31;
                default: sv = 5'($urandom);
            endcase
            if (k % 37 == 36) idle(1);
            issue(hm, $urandom, $urandom, $urandom, sv, hm ? "R4" : "R8");
        end
        idle(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule